// File: doc/BRIEF.md
# NAND Bus Strobe Timing Generator

This block turns one request for a single NAND bus cycle (command latch, address latch, data write or data read) into the chip-enable, latch-enable, write-strobe and read-strobe waveforms. Each waveform has programmable durations. It also inserts the wait intervals that the flash needs around these cycles. All durations come from two 32-bit timing words, and all counts are in controller clock cycles. Each field holds its cycle count minus a fixed offset, and that offset depends on the field.

A sequencer above this block offers one bus cycle at a time on `req_valid`/`req_kind`. A cycle is accepted when `req_ready` is high. The block samples both timing words at acceptance. It then runs the cycle without further input and reports the end with a one-cycle `done` pulse. On a read cycle, `cap_pulse` marks the clock in which the data pins should be captured. The read strobe phase is stretched if needed so that this capture point always falls while chip enable is still low.

Top module: `nand_strobe_gen`

## Requirements
- R1: During and directly after reset, `req_ready`=1, `ce_n`=`we_n`=`re_n`=1, and `cle`=`ale`=`cap_pulse`=`done`=0.
- R2: A request is accepted on a clock edge where `req_ready` and `req_valid` are both high. `req_kind` encodes the cycle type: 0 command, 1 address, 2 data write, 3 data read. From the next cycle, `req_ready` stays low through the `done` cycle. The cycle lasts lead + setup + strobe + hold + tail + 1 clocks.
- R3: On command, address and write cycles, chip enable is low with both strobes high for `tim_main[15:14]`+2 clocks. Then `we_n` is low for `tim_main[11:8]`+1 clocks.
- R4: After `we_n` rises, chip enable stays low for `tim_main[13:12]`+1 clocks.
- R5: After chip enable rises, the block waits before `done`. The wait is `tim_main[27:24]`+1 clocks for a command, `tim_aux[3:0]`+3 clocks for an address, and `tim_main[19:16]`+1 clocks for a data write.
- R6: A read cycle starts with chip enable high for `tim_main[23:20]`+3 clocks. Then chip enable is low with both strobes high for `tim_main[15:14]`+2 clocks.
- R7: On a read, `re_n` is low for `tim_main[3:0]`+1 clocks. It is then high, with chip enable still low, for at least `tim_main[5:4]`+1 clocks.
- R8: Each read gives exactly one `cap_pulse`, `tim_main[31:28]`+1 clocks after the first clock with `re_n` low. Non-read cycles give none.
- R9: If the capture point falls later than the end of the read-high interval, chip enable stays low with `re_n` high until the capture clock, and chip enable rises after that clock.
- R10: `cle` is high exactly while chip enable is low on a command cycle, and `ale` is high exactly while chip enable is low on an address cycle. The two strobes are never low together.
- R11: The timing words are sampled at acceptance. Changing them while a cycle is running has no effect on that cycle.
- R12: `done` is a single-clock pulse, and `req_ready` is high in the clock after it. While a cycle is busy, `req_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus cycle request |
| req_kind | input | 2 | Cycle type: 0 command, 1 address, 2 write, 3 read |
| tim_main | input | 32 | Main timing word (strobe, setup, delay fields) |
| tim_aux | input | 32 | Auxiliary timing word, bits 3:0 address-to-data delay |
| req_ready | output | 1 | Idle, request may be accepted |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| cap_pulse | output | 1 | Capture read data this clock |
| done | output | 1 | Bus cycle finished |

## Verification
The assertions assume that `rst_n` is held low over at least one clock edge before use. They also assume that `req_kind` and the timing words are stable at the accepting edge. The stimulus changes inputs only at falling edges, well away from the sampling edge. It deliberately changes the timing words and raises `req_valid` while a cycle is busy, to exercise the cases the assertions and requirements say must have no effect. Field values cover the all-zero and all-ones extremes, as well as capture points that fall both inside and beyond the read strobe.

// File: rtl/nst_pkg.sv
package nst_pkg;

    typedef enum logic [1:0] {
        KIND_CMD   = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_READ  = 2'd3
    } bus_kind_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_LEAD,
        PH_SETUP,
        PH_WLOW,
        PH_WHIGH,
        PH_RLOW,
        PH_RHIGH,
        PH_TAIL,
        PH_DONE
    } phase_e;

    // field positions inside the main timing word (software packs these)
    localparam int F_RP_LSB   = 0;
    localparam int F_RP_W     = 4;
    localparam int F_RH_LSB   = 4;
    localparam int F_RH_W     = 2;
    localparam int F_WP_LSB   = 8;
    localparam int F_WP_W     = 4;
    localparam int F_WH_LSB   = 12;
    localparam int F_WH_W     = 2;
    localparam int F_CS_LSB   = 14;
    localparam int F_CS_W     = 2;
    localparam int F_WHR_LSB  = 16;
    localparam int F_WHR_W    = 4;
    localparam int F_RR_LSB   = 20;
    localparam int F_RR_W     = 4;
    localparam int F_WB_LSB   = 24;
    localparam int F_WB_W     = 4;
    localparam int F_RESP_LSB = 28;
    localparam int F_RESP_W   = 4;
    // auxiliary word
    localparam int F_ADL_LSB  = 0;
    localparam int F_ADL_W    = 4;

    // stored value + offset = clock count
    localparam int OFS_BASE = 1;
    localparam int OFS_CS   = 2;
    localparam int OFS_RR   = 3;
    localparam int OFS_ADL  = 3;

    // longest single interval, and the longest read window measured from RE fall
    localparam int MAX_SPAN = (1 << F_RR_W) - 1 + OFS_RR;
    localparam int MAX_AGE  = 2 * MAX_SPAN;
    localparam int CNT_W    = $clog2(MAX_AGE + 1);

    // reload values are (count - 1); resp is the capture index itself
    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] wlow;
        logic [CNT_W-1:0] whigh;
        logic [CNT_W-1:0] rlow;
        logic [CNT_W-1:0] rhigh;
        logic [CNT_W-1:0] resp;
        logic [CNT_W-1:0] lead;
        logic [CNT_W-1:0] tail_cmd;
        logic [CNT_W-1:0] tail_addr;
        logic [CNT_W-1:0] tail_write;
    } span_t;

endpackage

// File: rtl/nst_span_decode.sv
module nst_span_decode
    import nst_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic [TW-1:0] cfg_main,
    input  logic [TW-1:0] cfg_aux,
    output span_t         spans
);

    localparam logic [TW-1:0] ONE = TW'(1);

    function automatic logic [CNT_W-1:0] pick(input logic [TW-1:0] r, input int lsb,
                                             input int w, input int adj);
        logic [TW-1:0] m;
        m = (r >> lsb) & ((ONE << w) - ONE);
        return CNT_W'(m) + CNT_W'(adj);
    endfunction

    always_comb begin
        spans.setup      = pick(cfg_main, F_CS_LSB,   F_CS_W,   OFS_CS - 1);
        spans.wlow       = pick(cfg_main, F_WP_LSB,   F_WP_W,   OFS_BASE - 1);
        spans.whigh      = pick(cfg_main, F_WH_LSB,   F_WH_W,   OFS_BASE - 1);
        spans.rlow       = pick(cfg_main, F_RP_LSB,   F_RP_W,   OFS_BASE - 1);
        spans.rhigh      = pick(cfg_main, F_RH_LSB,   F_RH_W,   OFS_BASE - 1);
        spans.resp       = pick(cfg_main, F_RESP_LSB, F_RESP_W, OFS_BASE);
        spans.lead       = pick(cfg_main, F_RR_LSB,   F_RR_W,   OFS_RR - 1);
        spans.tail_cmd   = pick(cfg_main, F_WB_LSB,   F_WB_W,   OFS_BASE - 1);
        spans.tail_write = pick(cfg_main, F_WHR_LSB,  F_WHR_W,  OFS_BASE - 1);
        spans.tail_addr  = pick(cfg_aux,  F_ADL_LSB,  F_ADL_W,  OFS_ADL - 1);
    end

endmodule

// File: rtl/nst_pin_map.sv
module nst_pin_map
    import nst_pkg::*;
(
    input  phase_e    phase,
    input  bus_kind_e kind,
    output logic      ce_n,
    output logic      cle,
    output logic      ale,
    output logic      we_n,
    output logic      re_n,
    output logic      ready,
    output logic      done
);

    logic selected;

    always_comb begin
        selected = (phase == PH_SETUP) || (phase == PH_WLOW) || (phase == PH_WHIGH) ||
                   (phase == PH_RLOW)  || (phase == PH_RHIGH);
        ce_n  = !selected;
        cle   = selected && (kind == KIND_CMD);
        ale   = selected && (kind == KIND_ADDR);
        we_n  = (phase != PH_WLOW);
        re_n  = (phase != PH_RLOW);
        ready = (phase == PH_IDLE);
        done  = (phase == PH_DONE);
    end

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
    import nst_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [TW-1:0] tim_main,
    input  logic [TW-1:0] tim_aux,
    output logic          req_ready,
    output logic          ce_n,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          re_n,
    output logic          cap_pulse,
    output logic          done
);

    typedef struct packed {
        phase_e           phase;
        bus_kind_e        kind;
        span_t            span;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] age;
    } ctx_t;

    ctx_t  ctx_d, ctx_q;
    span_t span_now;
    logic  in_read_strobe;

    nst_span_decode #(.TW(TW)) decode_i (
        .cfg_main (tim_main),
        .cfg_aux  (tim_aux),
        .spans    (span_now)
    );

    function automatic logic [CNT_W-1:0] tail_of(input span_t s, input bus_kind_e k);
        case (k)
            KIND_CMD:  return s.tail_cmd;
            KIND_ADDR: return s.tail_addr;
            default:   return s.tail_write;
        endcase
    endfunction

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    ctx_d.kind = bus_kind_e'(req_kind);
                    ctx_d.span = span_now;
                    ctx_d.age  = '0;
                    if (bus_kind_e'(req_kind) == KIND_READ) begin
                        ctx_d.phase = PH_LEAD;
                        ctx_d.cnt   = span_now.lead;
                    end else begin
                        ctx_d.phase = PH_SETUP;
                        ctx_d.cnt   = span_now.setup;
                    end
                end
            end
            PH_LEAD: begin
                if (ctx_q.cnt == '0) begin
                    ctx_d.phase = PH_SETUP;
                    ctx_d.cnt   = ctx_q.span.setup;
                end else begin
                    ctx_d.cnt = ctx_q.cnt - 1'b1;
                end
            end
            PH_SETUP: begin
                if (ctx_q.cnt == '0) begin
                    ctx_d.age = '0;
                    if (ctx_q.kind == KIND_READ) begin
                        ctx_d.phase = PH_RLOW;
                        ctx_d.cnt   = ctx_q.span.rlow;
                    end else begin
                        ctx_d.phase = PH_WLOW;
                        ctx_d.cnt   = ctx_q.span.wlow;
                    end
                end else begin
                    ctx_d.cnt = ctx_q.cnt - 1'b1;
                end
            end
            PH_WLOW: begin
                if (ctx_q.cnt == '0) begin
                    ctx_d.phase = PH_WHIGH;
                    ctx_d.cnt   = ctx_q.span.whigh;
                end else begin
                    ctx_d.cnt = ctx_q.cnt - 1'b1;
                end
            end
            PH_WHIGH: begin
                if (ctx_q.cnt == '0) begin
                    ctx_d.phase = PH_TAIL;
                    ctx_d.cnt   = tail_of(ctx_q.span, ctx_q.kind);
                end else begin
                    ctx_d.cnt = ctx_q.cnt - 1'b1;
                end
            end
            PH_RLOW: begin
                ctx_d.age = ctx_q.age + 1'b1;
                if (ctx_q.cnt == '0) begin
                    ctx_d.phase = PH_RHIGH;
                    ctx_d.cnt   = ctx_q.span.rhigh;
                end else begin
                    ctx_d.cnt = ctx_q.cnt - 1'b1;
                end
            end
            PH_RHIGH: begin
                ctx_d.age = ctx_q.age + 1'b1;
                if (ctx_q.cnt != '0) begin
                    ctx_d.cnt = ctx_q.cnt - 1'b1;
                end else if (ctx_q.age >= ctx_q.span.resp) begin
                    ctx_d.phase = PH_DONE;
                end
            end
            PH_TAIL: begin
                if (ctx_q.cnt == '0) begin
                    ctx_d.phase = PH_DONE;
                end else begin
                    ctx_d.cnt = ctx_q.cnt - 1'b1;
                end
            end
            PH_DONE: begin
                ctx_d.phase = PH_IDLE;
            end
            default: begin
                ctx_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{phase: PH_IDLE, kind: KIND_CMD, span: '0, cnt: '0, age: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign in_read_strobe = (ctx_q.phase == PH_RLOW) || (ctx_q.phase == PH_RHIGH);
    assign cap_pulse      = in_read_strobe && (ctx_q.age == ctx_q.span.resp);

    nst_pin_map pins_i (
        .phase (ctx_q.phase),
        .kind  (ctx_q.kind),
        .ce_n  (ce_n),
        .cle   (cle),
        .ale   (ale),
        .we_n  (we_n),
        .re_n  (re_n),
        .ready (req_ready),
        .done  (done)
    );

endmodule

// File: rtl/nand_strobe_gen_checker.sv
module nand_strobe_gen_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic ce_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n,
    input logic cap_pulse,
    input logic done
);

    // R1: reset leaves the bus idle
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (req_ready && ce_n && we_n && re_n && !done));

    // R2: an accepted request makes the block busy
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

    // R3: the write strobe only moves while the device is selected
    a_r3_we_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);

    // R8: capture happens inside a selected read window, never on latch cycles
    a_r8_cap_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |-> (!ce_n && !cle && !ale && we_n));

    // R10: strobes exclusive, latch enables exclusive
    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n) && !(cle && ale));

    // R12: done is one clock wide and the block is ready right after
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

endmodule

bind nand_strobe_gen nand_strobe_gen_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ce_n      (ce_n),
    .cle       (cle),
    .ale       (ale),
    .we_n      (we_n),
    .re_n      (re_n),
    .cap_pulse (cap_pulse),
    .done      (done)
);

// File: tb/nand_strobe_gen_tb_top.sv
module nand_strobe_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [31:0] tim_main = '0;
    logic [31:0] tim_aux = '0;
    logic req_ready, ce_n, cle, ale, we_n, re_n, cap_pulse, done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    nand_strobe_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .tim_main(tim_main), .tim_aux(tim_aux), .req_ready(req_ready),
        .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
        .cap_pulse(cap_pulse), .done(done)
    );

    typedef struct {
        int kind;
        int lead, setup, wlow, rlow, post, tail;
        int ncle, nale, ncap, capidx, total;
        bit late;
    } exp_t;

    exp_t sb[$];

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int fv(input logic [31:0] r, input int lsb, input int w);
        return int'((r >> lsb) & ((32'd1 << w) - 32'd1));
    endfunction

    function automatic logic [31:0] mk(input int rp, input int rh, input int wp, input int wh,
                                       input int cs, input int whr, input int rr, input int wb,
                                       input int resp);
        return 32'(rp) | (32'(rh) << 4) | (32'(wp) << 8) | (32'(wh) << 12) | (32'(cs) << 14) |
               (32'(whr) << 16) | (32'(rr) << 20) | (32'(wb) << 24) | (32'(resp) << 28);
    endfunction

    // expected waveform of one bus cycle from the requirement formulas
    function automatic exp_t expect_of(input int kind, input logic [31:0] m, input logic [31:0] a,
                                       input bit late);
        exp_t e;
        int rp, rh, rsp, win;
        e.kind  = kind;
        e.late  = late;
        e.setup = fv(m, 14, 2) + 2;
        rp  = fv(m, 0, 4) + 1;
        rh  = fv(m, 4, 2) + 1;
        rsp = fv(m, 28, 4) + 1;
        if (kind == 3) begin
            e.lead = fv(m, 20, 4) + 3;
            e.wlow = 0;
            e.rlow = rp;
            win = (rp + rh > rsp + 1) ? rp + rh : rsp + 1;
            e.post = win - rp;
            e.tail = 0;
            e.ncap = 1;
            e.capidx = rsp;
        end else begin
            e.lead = 0;
            e.wlow = fv(m, 8, 4) + 1;
            e.rlow = 0;
            e.post = fv(m, 12, 2) + 1;
            e.tail = (kind == 0) ? fv(m, 24, 4) + 1 :
                     (kind == 1) ? fv(a, 0, 4) + 3 : fv(m, 16, 4) + 1;
            e.ncap = 0;
            e.capidx = 0;
        end
        e.ncle  = (kind == 0) ? e.setup + e.wlow + e.post : 0;
        e.nale  = (kind == 1) ? e.setup + e.wlow + e.post : 0;
        e.total = e.lead + e.setup + e.wlow + e.rlow + e.post + e.tail + 1;
        return e;
    endfunction

    // driver: one request; optional timing change after acceptance (R11)
    // and optional extra valid while busy (R12)
    task automatic issue(input int kind, input logic [31:0] m, input logic [31:0] a,
                         input bit change_after, input bit extra_valid);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        tim_main  = m;
        tim_aux   = a;
        sb.push_back(expect_of(kind, m, a, change_after));
        @(negedge clk);
        if (change_after) begin
            tim_main = ~m;
            tim_aux  = ~a;
        end
        if (extra_valid) begin
            req_kind = 2'd3;
            @(negedge clk);
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    // monitor
    bit active = 0;
    bit seen_ce, seen_str, seen_re, chk_after;
    int c_lead, c_setup, c_wlow, c_rlow, c_post, c_tail, c_cle, c_ale, c_cap, c_capidx, c_tot, age;
    int dones = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (chk_after) begin
                chk_after = 0;
                check("R12", "done width", int'(done), 0);
                check("R12", "ready after done", int'(req_ready), 1);
            end
            if (!active && !req_ready) begin
                active = 1; seen_ce = 0; seen_str = 0; seen_re = 0;
                c_lead = 0; c_setup = 0; c_wlow = 0; c_rlow = 0; c_post = 0; c_tail = 0;
                c_cle = 0; c_ale = 0; c_cap = 0; c_capidx = -1; c_tot = 0; age = 0;
            end
            if (!active) continue;
            c_tot++;
            if (cle) c_cle++;
            if (ale) c_ale++;
            if (seen_re) age++;
            if (!re_n && !seen_re) begin seen_re = 1; age = 0; end
            if (cap_pulse) begin c_cap++; c_capidx = age; end
            if (done) begin
                exp_t e;
                active = 0;
                dones++;
                chk_after = 1;
                if (sb.size() == 0) begin
                    check("R12", "unexpected bus cycle", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check("R6", "lead", c_lead, e.lead);
                    check("R3", "setup", c_setup, e.setup);
                    check("R3", "we low", c_wlow, e.wlow);
                    check("R7", "re low", c_rlow, e.rlow);
                    check(e.kind == 3 ? "R9" : "R4", "hold", c_post, e.post);
                    check("R5", "tail", c_tail, e.tail);
                    check("R10", "cle cycles", c_cle, e.ncle);
                    check("R10", "ale cycles", c_ale, e.nale);
                    check("R8", "capture count", c_cap, e.ncap);
                    if (e.kind == 3) check("R8", "capture index", c_capidx, e.capidx);
                    check(e.late ? "R11" : "R2", "total", c_tot, e.total);
                end
            end else if (ce_n) begin
                if (seen_ce) c_tail++; else c_lead++;
            end else begin
                seen_ce = 1;
                if (!we_n) begin c_wlow++; seen_str = 1; end
                else if (!re_n) begin c_rlow++; seen_str = 1; end
                else if (seen_str) c_post++;
                else c_setup++;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "ready", int'(req_ready), 1);
        check("R1", "ce_n", int'(ce_n), 1);
        check("R1", "we_n/re_n", int'(we_n && re_n), 1);
        check("R1", "latches/cap/done", int'(cle | ale | cap_pulse | done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after release", int'(req_ready && ce_n), 1);

        issue(0, mk(0,0,0,0,0,0,0,0,0), 32'h0, 0, 0);                  // minimum command
        issue(1, mk(2,1,5,2,1,3,4,6,2), 32'h5, 0, 0);                  // address
        issue(2, mk(0,0,15,3,3,15,0,0,0), 32'h0, 0, 0);                // write, max fields
        issue(3, mk(4,1,0,0,1,0,2,0,0), 32'h0, 0, 0);                  // capture inside RE low
        issue(3, mk(0,0,0,0,0,0,0,0,15), 32'h0, 0, 0);                 // late capture stretch
        issue(3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);                  // read, all max
        issue(0, mk(1,0,3,1,2,0,0,9,0), 32'h0, 1, 0);                  // timing change mid-cycle
        issue(3, mk(2,2,0,0,0,0,1,0,5), 32'h0, 1, 0);                  // read, timing change
        issue(2, mk(0,0,2,1,0,7,0,0,0), 32'h0, 0, 1);                  // valid while busy
        issue(1, mk(0,0,0,0,0,0,0,0,0), 32'hF, 0, 0);                  // tADL max
        issue(1, mk(0,0,0,0,0,0,0,0,0), 32'h0, 0, 0);                  // tADL min

        while (sb.size() != 0 || active || chk_after) @(negedge clk);
        repeat (5) @(negedge clk);
        check("R12", "bus cycles completed", dones, 11);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule